// File: doc/BRIEF.md
# Burst-of-four SRAM write formatter

This block turns write requests from user logic into the pin-level write sequence of a burst-of-four synchronous SRAM port. The user logic runs at half the memory clock rate. The block gives it a half-rate tick, `usr_tick`, on the memory clock. Each request carries one address, four data words and four active-low byte-write masks. Accepted requests go into a four-entry buffer. The user side may push into this buffer only while `req_full` is low.

On the memory side, address and write select are single data rate: one value per memory clock. Data and byte-write masks are double data rate, so each clock carries a rising-edge value and a falling-edge value. The two halves leave the block as separate lanes, ready for an output DDR register stage. One burst of four words therefore takes two memory clocks. The parameter `BURST_CYCLES` sets how many memory clocks one write slot uses. It must be at least two, and the clocks beyond the second are idle.

Top module: `qdr_burst_wr_fmt`

## Requirements
- R1: `usr_tick` changes value on every memory clock. A request is sampled only on a rising edge at which `usr_tick` is 1, and `req_valid` on any other edge has no effect.
- R2: A request is accepted when `req_valid` and `usr_tick` are 1 and `req_full` is 0. `req_full` is 1 exactly while four accepted requests are waiting and none of them has been started.
- R3: A request offered while `req_full` is 1 is dropped, and `push_err` is 1 for the one memory clock that follows that edge.
- R4: Bursts leave in the order in which their requests were accepted.
- R5: `mem_ws_n` is 0 for exactly one memory clock per burst. `mem_addr` carries the request address in that same clock.
- R6: In the write-select clock, `mem_d_rise` and `mem_d_fall` carry word 0 and word 1, and the byte-write lanes carry masks 0 and 1. In the next clock, the data lanes carry words 2 and 3 and the byte-write lanes carry masks 2 and 3. Word k is bits [k*DATA_W +: DATA_W] of `req_data`, and mask k is bits [k*BW_W +: BW_W] of `req_bw_n`, where BW_W = DATA_W/BYTE_W.
- R7: In every clock that carries no burst beat, `mem_ws_n` is 1, both byte-write lanes are all ones, and the data and address lanes are zero.
- R8: The write-select pulses of two bursts are at least `BURST_CYCLES` clocks apart. When a request is already waiting, the next burst starts exactly `BURST_CYCLES` clocks after the previous one.
- R9: A request accepted at edge E into an empty buffer, while no burst is in flight, drives `mem_ws_n` low in the clock after edge E+1.
- R10: While `rst_n` is 0, the outputs read `mem_ws_n`=1, byte-write lanes all ones, `req_full`=0, `push_err`=0, and the buffer is emptied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Active-low synchronous reset |
| usr_tick | output | 1 | Half-rate tick; requests are sampled on the edge where it is 1 |
| req_valid | input | 1 | Request offered |
| req_addr | input | ADDR_W | Burst address |
| req_data | input | 4*DATA_W | Four data words, word 0 in the low bits |
| req_bw_n | input | 4*BW_W | Four active-low byte-write masks, mask 0 in the low bits |
| req_full | output | 1 | Buffer holds four requests |
| push_err | output | 1 | One-clock pulse after a request dropped because the buffer was full |
| mem_ws_n | output | 1 | Active-low write select |
| mem_addr | output | ADDR_W | Address, single data rate |
| mem_d_rise | output | DATA_W | Data for the rising half of the clock |
| mem_d_fall | output | DATA_W | Data for the falling half of the clock |
| mem_bw_rise_n | output | BW_W | Byte-write mask for the rising half |
| mem_bw_fall_n | output | BW_W | Byte-write mask for the falling half |

## Verification
The hardest state to reach is a full buffer. With the default slot of two clocks, the buffer drains one burst per user tick, so it can never fill. The bench therefore sets the slot to four clocks and pushes on every tick. The buffer then fills, some offers meet `req_full`, and the bench can check the drop and the `push_err` pulse. The bench also checks that the bursts which follow keep their order and start back to back at the slot spacing. A separate step drives `req_valid` on an edge where the tick is low and confirms that no burst comes of it.

// File: rtl/qdr_burst_wr_pkg.sv
package qdr_burst_wr_pkg;
    localparam int unsigned WORDS_PER_BURST = 4;
    localparam int unsigned BUF_DEPTH       = 4;
endpackage

// File: rtl/qdr_burst_wr_fifo.sv
module qdr_burst_wr_fifo #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic             full,
    output logic             empty
);
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0] wr;
        logic [PW-1:0] rd;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    assign full    = (st_q.cnt == CW'(DEPTH));
    assign empty   = (st_q.cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem_q[st_q.rd];

    always_comb begin
        st_d = st_q;
        if (do_push) st_d.wr = (st_q.wr == PW'(DEPTH - 1)) ? '0 : st_q.wr + 1'b1;
        if (do_pop)  st_d.rd = (st_q.rd == PW'(DEPTH - 1)) ? '0 : st_q.rd + 1'b1;
        if (do_push && !do_pop)      st_d.cnt = st_q.cnt + 1'b1;
        else if (do_pop && !do_push) st_d.cnt = st_q.cnt - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[st_q.wr] <= din;
    end
endmodule

// File: rtl/qdr_burst_wr_serdes.sv
module qdr_burst_wr_serdes #(
    parameter int unsigned ADDR_W       = 18,
    parameter int unsigned DATA_W       = 18,
    parameter int unsigned BW_W         = 2,
    parameter int unsigned BURST_CYCLES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                have_item,
    input  logic [ADDR_W-1:0]   in_addr,
    input  logic [4*DATA_W-1:0] in_data,
    input  logic [4*BW_W-1:0]   in_bw_n,
    output logic                pop,
    output logic                ws_n,
    output logic [ADDR_W-1:0]   addr,
    output logic [DATA_W-1:0]   d_rise,
    output logic [DATA_W-1:0]   d_fall,
    output logic [BW_W-1:0]     bw_rise_n,
    output logic [BW_W-1:0]     bw_fall_n
);
    localparam int unsigned CW = (BURST_CYCLES > 2) ? $clog2(BURST_CYCLES) : 1;

    typedef struct packed {
        logic                busy;
        logic [CW-1:0]       beat;
        logic [2*DATA_W-1:0] hold_d;
        logic [2*BW_W-1:0]   hold_bw;
        logic                ws_n;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   d_rise;
        logic [DATA_W-1:0]   d_fall;
        logic [BW_W-1:0]     bw_rise_n;
        logic [BW_W-1:0]     bw_fall_n;
    } ser_st_t;

    ser_st_t st_d, st_q;
    logic    last_beat;

    assign last_beat = (st_q.beat == CW'(BURST_CYCLES - 1));

    always_comb begin
        st_d           = st_q;
        pop            = 1'b0;
        st_d.ws_n      = 1'b1;
        st_d.addr      = '0;
        st_d.d_rise    = '0;
        st_d.d_fall    = '0;
        st_d.bw_rise_n = '1;
        st_d.bw_fall_n = '1;
        if ((!st_q.busy || last_beat) && have_item) begin
            pop            = 1'b1;
            st_d.busy      = 1'b1;
            st_d.beat      = '0;
            st_d.ws_n      = 1'b0;
            st_d.addr      = in_addr;
            st_d.d_rise    = in_data[0 +: DATA_W];
            st_d.d_fall    = in_data[DATA_W +: DATA_W];
            st_d.bw_rise_n = in_bw_n[0 +: BW_W];
            st_d.bw_fall_n = in_bw_n[BW_W +: BW_W];
            st_d.hold_d    = in_data[2*DATA_W +: 2*DATA_W];
            st_d.hold_bw   = in_bw_n[2*BW_W +: 2*BW_W];
        end else if (st_q.busy) begin
            if (last_beat) begin
                st_d.busy = 1'b0;
            end else begin
                st_d.beat = st_q.beat + 1'b1;
                if (st_q.beat == '0) begin
                    st_d.d_rise    = st_q.hold_d[0 +: DATA_W];
                    st_d.d_fall    = st_q.hold_d[DATA_W +: DATA_W];
                    st_d.bw_rise_n = st_q.hold_bw[0 +: BW_W];
                    st_d.bw_fall_n = st_q.hold_bw[BW_W +: BW_W];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.ws_n      <= 1'b1;
            st_q.bw_rise_n <= '1;
            st_q.bw_fall_n <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign ws_n      = st_q.ws_n;
    assign addr      = st_q.addr;
    assign d_rise    = st_q.d_rise;
    assign d_fall    = st_q.d_fall;
    assign bw_rise_n = st_q.bw_rise_n;
    assign bw_fall_n = st_q.bw_fall_n;
endmodule

// File: rtl/qdr_burst_wr_fmt.sv
module qdr_burst_wr_fmt #(
    parameter int unsigned ADDR_W       = 18,
    parameter int unsigned DATA_W       = 18,
    parameter int unsigned BYTE_W       = 9,
    parameter int unsigned BURST_CYCLES = 2
) (
    input  logic                                clk,
    input  logic                                rst_n,
    output logic                                usr_tick,
    input  logic                                req_valid,
    input  logic [ADDR_W-1:0]                   req_addr,
    input  logic [4*DATA_W-1:0]                 req_data,
    input  logic [4*(DATA_W/BYTE_W)-1:0]        req_bw_n,
    output logic                                req_full,
    output logic                                push_err,
    output logic                                mem_ws_n,
    output logic [ADDR_W-1:0]                   mem_addr,
    output logic [DATA_W-1:0]                   mem_d_rise,
    output logic [DATA_W-1:0]                   mem_d_fall,
    output logic [(DATA_W/BYTE_W)-1:0]          mem_bw_rise_n,
    output logic [(DATA_W/BYTE_W)-1:0]          mem_bw_fall_n
);
    import qdr_burst_wr_pkg::*;

    localparam int unsigned BW_W    = DATA_W / BYTE_W;
    localparam int unsigned ENTRY_W = ADDR_W + WORDS_PER_BURST * (DATA_W + BW_W);

    typedef struct packed {
        logic tick;
        logic err;
    } top_st_t;

    top_st_t st_d, st_q;
    logic    push, pop, buf_full, buf_empty;
    logic [ENTRY_W-1:0] entry_in, entry_out;

    assign push     = req_valid && st_q.tick && !buf_full;
    assign entry_in = {req_addr, req_data, req_bw_n};

    always_comb begin
        st_d      = st_q;
        st_d.tick = !st_q.tick;
        st_d.err  = req_valid && st_q.tick && buf_full;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    qdr_burst_wr_fifo #(
        .WIDTH (ENTRY_W),
        .DEPTH (BUF_DEPTH)
    ) i_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (pop),
        .din   (entry_in),
        .dout  (entry_out),
        .full  (buf_full),
        .empty (buf_empty)
    );

    qdr_burst_wr_serdes #(
        .ADDR_W       (ADDR_W),
        .DATA_W       (DATA_W),
        .BW_W         (BW_W),
        .BURST_CYCLES (BURST_CYCLES)
    ) i_serdes (
        .clk       (clk),
        .rst_n     (rst_n),
        .have_item (!buf_empty),
        .in_addr   (entry_out[ENTRY_W-1 -: ADDR_W]),
        .in_data   (entry_out[4*BW_W +: 4*DATA_W]),
        .in_bw_n   (entry_out[0 +: 4*BW_W]),
        .pop       (pop),
        .ws_n      (mem_ws_n),
        .addr      (mem_addr),
        .d_rise    (mem_d_rise),
        .d_fall    (mem_d_fall),
        .bw_rise_n (mem_bw_rise_n),
        .bw_fall_n (mem_bw_fall_n)
    );

    assign usr_tick = st_q.tick;
    assign req_full = buf_full;
    assign push_err = st_q.err;
endmodule

// File: rtl/qdr_burst_wr_fmt_chk.sv
module qdr_burst_wr_fmt_chk #(
    parameter int unsigned DATA_W       = 18,
    parameter int unsigned BW_W         = 2,
    parameter int unsigned BURST_CYCLES = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              usr_tick,
    input logic              req_valid,
    input logic              req_full,
    input logic              push_err,
    input logic              mem_ws_n,
    input logic [DATA_W-1:0] mem_d_rise,
    input logic [DATA_W-1:0] mem_d_fall,
    input logic [BW_W-1:0]   mem_bw_rise_n,
    input logic [BW_W-1:0]   mem_bw_fall_n
);
    logic [15:0] gap_q;
    logic        seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (!mem_ws_n) begin
            gap_q  <= 16'd1;
            seen_q <= 1'b1;
        end else if (gap_q != 16'hFFFF) begin
            gap_q  <= gap_q + 16'd1;
        end
    end

    // R1
    tick_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (usr_tick != $past(usr_tick)));

    // R5
    ws_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ws_n |=> mem_ws_n);

    // R7
    idle_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && mem_ws_n && $past(mem_ws_n)) |->
        (&mem_bw_rise_n && &mem_bw_fall_n && mem_d_rise == '0 && mem_d_fall == '0));

    // R3
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_err |-> ($past(rst_n) && $past(req_valid && usr_tick && req_full)));

    // R8
    slot_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ws_n && seen_q) |-> (gap_q >= 16'(BURST_CYCLES)));
endmodule

bind qdr_burst_wr_fmt qdr_burst_wr_fmt_chk #(
    .DATA_W       (DATA_W),
    .BW_W         (DATA_W / BYTE_W),
    .BURST_CYCLES (BURST_CYCLES)
) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .usr_tick      (usr_tick),
    .req_valid     (req_valid),
    .req_full      (req_full),
    .push_err      (push_err),
    .mem_ws_n      (mem_ws_n),
    .mem_d_rise    (mem_d_rise),
    .mem_d_fall    (mem_d_fall),
    .mem_bw_rise_n (mem_bw_rise_n),
    .mem_bw_fall_n (mem_bw_fall_n)
);

// File: tb/test_qdr_burst_wr_fmt.sv
module test_qdr_burst_wr_fmt;
    localparam int AW = 18;
    localparam int DW = 18;
    localparam int BYW = 9;
    localparam int BWW = DW / BYW;
    localparam int BC = 4;
    localparam int IW = AW + 4*DW + 4*BWW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic usr_tick, req_valid, req_full, push_err, mem_ws_n;
    logic [AW-1:0] req_addr, mem_addr;
    logic [4*DW-1:0] req_data;
    logic [4*BWW-1:0] req_bw_n;
    logic [DW-1:0] mem_d_rise, mem_d_fall;
    logic [BWW-1:0] mem_bw_rise_n, mem_bw_fall_n;

    int checks = 0, fails = 0, cyc = 0, bursts = 0;
    int last_ws = -1, first_ws = -1, exact_gap = 0;
    logic [IW-1:0] sb[$];
    bit full_seen = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    qdr_burst_wr_fmt #(.ADDR_W(AW), .DATA_W(DW), .BYTE_W(BYW), .BURST_CYCLES(BC)) i_qdr_burst_wr_fmt (
        .clk(clk), .rst_n(rst_n), .usr_tick(usr_tick), .req_valid(req_valid),
        .req_addr(req_addr), .req_data(req_data), .req_bw_n(req_bw_n),
        .req_full(req_full), .push_err(push_err), .mem_ws_n(mem_ws_n),
        .mem_addr(mem_addr), .mem_d_rise(mem_d_rise), .mem_d_fall(mem_d_fall),
        .mem_bw_rise_n(mem_bw_rise_n), .mem_bw_fall_n(mem_bw_fall_n));

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: scoreboard pop and lane checks
    logic [IW-1:0] cur;
    bit second = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (second) begin
                second = 0;
                chk(mem_ws_n == 1'b1, "R5 ws high on beat 2", mem_ws_n, 1);
                chk(mem_d_rise == cur[4*BWW+2*DW +: DW] && mem_d_fall == cur[4*BWW+3*DW +: DW],
                    "R6 words 2,3", {mem_d_rise, mem_d_fall}, {cur[4*BWW+2*DW +: DW], cur[4*BWW+3*DW +: DW]});
                chk(mem_bw_rise_n == cur[2*BWW +: BWW] && mem_bw_fall_n == cur[3*BWW +: BWW],
                    "R6 masks 2,3", {mem_bw_rise_n, mem_bw_fall_n}, {cur[2*BWW +: BWW], cur[3*BWW +: BWW]});
            end else if (!mem_ws_n) begin
                bursts++;
                if (first_ws < 0) first_ws = cyc;
                if (last_ws >= 0) begin
                    chk(cyc - last_ws >= BC, "R8 slot spacing", cyc - last_ws, BC);
                    if (cyc - last_ws == BC) exact_gap++;
                end
                last_ws = cyc;
                if (sb.size() == 0) begin
                    chk(0, "R1 unexpected burst", mem_addr, 0);
                end else begin
                    cur = sb.pop_front();
                    second = 1;
                    chk(mem_addr == cur[IW-1 -: AW], "R4 R5 address order", mem_addr, cur[IW-1 -: AW]);
                    chk(mem_d_rise == cur[4*BWW +: DW] && mem_d_fall == cur[4*BWW+DW +: DW],
                        "R6 words 0,1", {mem_d_rise, mem_d_fall}, {cur[4*BWW +: DW], cur[4*BWW+DW +: DW]});
                    chk(mem_bw_rise_n == cur[0 +: BWW] && mem_bw_fall_n == cur[BWW +: BWW],
                        "R6 masks 0,1", {mem_bw_rise_n, mem_bw_fall_n}, {cur[0 +: BWW], cur[BWW +: BWW]});
                end
            end else begin
                chk(&mem_bw_rise_n && &mem_bw_fall_n && mem_d_rise == 0 && mem_d_fall == 0 && mem_addr == 0,
                    "R7 idle lanes", {mem_addr, mem_d_rise, mem_bw_rise_n}, {{AW{1'b0}}, {DW{1'b0}}, {BWW{1'b1}}});
            end
        end
    end

    // driver: offer one request on the next tick edge
    task automatic offer(input logic [AW-1:0] a, output int drive_cyc);
        bit was_full;
        @(negedge clk);
        while (!usr_tick) @(negedge clk);
        req_valid = 1;
        req_addr  = a;
        for (int k = 0; k < 4; k++) req_data[k*DW +: DW] = DW'($urandom);
        req_bw_n  = (4*BWW)'($urandom);
        was_full  = req_full;
        drive_cyc = cyc;
        if (was_full) full_seen = 1;
        else sb.push_back({req_addr, req_data, req_bw_n});
        @(negedge clk);
        req_valid = 0;
        chk(push_err == was_full, "R3 push_err after offer", push_err, was_full);
    endtask

    initial begin
        int dc;
        req_valid = 0; req_addr = 0; req_data = 0; req_bw_n = 0;
        repeat (4) @(negedge clk);
        // R10 reset state
        chk(mem_ws_n == 1 && &mem_bw_rise_n && &mem_bw_fall_n, "R10 reset lanes", {mem_ws_n, mem_bw_rise_n}, {1'b1, {BWW{1'b1}}});
        chk(req_full == 0 && push_err == 0, "R10 reset flags", {req_full, push_err}, 0);
        rst_n = 1;
        repeat (3) @(negedge clk);

        // R9 latency from idle
        offer(18'h1A5A5, dc);
        repeat (8) @(negedge clk);
        chk(first_ws == dc + 2, "R9 latency", first_ws, dc + 2);

        // R1 off-tick offer ignored
        @(negedge clk);
        while (usr_tick) @(negedge clk);
        req_valid = 1; req_addr = 18'h3FFFF; req_data = '1; req_bw_n = '0;
        @(negedge clk);
        req_valid = 0;
        repeat (12) @(negedge clk);
        chk(bursts == 1, "R1 off-tick ignored", bursts, 1);
        chk(push_err == 0, "R1 no error off-tick", push_err, 0);

        // R2 R3 fill under slow drain
        for (int i = 0; i < 12; i++) offer(AW'(18'h100 + i), dc);
        chk(full_seen, "R2 full reached", full_seen, 1);
        repeat (40) @(negedge clk);
        chk(req_full == 0, "R2 full cleared after drain", req_full, 0);

        // mixed pattern with gaps
        for (int i = 0; i < 6; i++) begin
            offer(AW'($urandom), dc);
            repeat (i) @(negedge clk);
        end
        repeat (40) @(negedge clk);
        chk(sb.size() == 0, "R4 all bursts delivered", sb.size(), 0);
        chk(exact_gap > 0, "R8 back-to-back at slot length", exact_gap, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog R4 actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule